// File: doc/BRIEF.md
# BCD Calendar Clock with Multipurpose Output

This block keeps wall-clock time and date in packed BCD. The fields are seconds, minutes, hours (24-hour), day of week, day of month, month, two-digit year and century. A free-running prescaler counts strobes from the 32.768 kHz timebase. The input `osc_edge` pulses once for every half period of that oscillator, so there are 2^PRESC_W strobes per second and 65536 at the default width. Each time the prescaler wraps, the time advances by one second. The carry runs all the way up to the century field. A year whose BCD value is a multiple of four gets a 29-day February, which is correct for every year up to 2099.

A single open-drain style pin serves three purposes. It can flag a matched alarm, carry a 512 Hz calibration tone, or carry one of four square-wave rates. The pin is modelled as a pull-down enable, `mp_oe`, together with the level seen on the wire, `mp_level`. When the pull-down is released, the wire reads high.

Software uses a parallel register port. Time fields sit at addresses 0 to 7: seconds, minutes, hours, day of week, date, month, year, century. Alarm targets sit at 8 to 12: seconds, minutes, hours, date, month. Address 13 is the alarm field-enable mask and address 14 is the control register. A read of addresses 0 to 7 returns a frozen copy taken on `rd_strobe`, so a carry cannot change the value partway through a read.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time reads 2000-01-01 00:00:00 with day of week 01: addresses 0..7 hold 00,00,00,01,01,01,00,20. Control reads 00 and the pin is released (`mp_oe`=0, `mp_level`=1).
- R2: The seconds field advances exactly once for every 2^PRESC_W `osc_edge` strobes, and never while `osc_edge` stays low.
- R3: Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and carry into the day.
- R4: Day of week (address 3) counts 01..07 and wraps from 07 to 01 at each midnight.
- R5: Day of month wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11; 29 for month 02 when the BCD year is a multiple of four, otherwise 28; 31 for all other months. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century.
- R6: A write to address 0..7 loads that field and clears the prescaler. The first advance after the write therefore lands 2^PRESC_W strobes after the write cycle.
- R7: A pulse on `rd_strobe` captures all time fields. Reads of addresses 0..7 return that capture and do not change while the time advances, until the next pulse.
- R8: The alarm flag (control bit 7) sets on the second update in which every field enabled in the mask equals its target. Mask bit 0 enables seconds, bit 1 minutes, bit 2 hours, bit 3 date and bit 4 month. An all-zero mask never matches. The flag stays set until a control write with bit 7 = 0.
- R9: Alarm mode (control bit 0 = 1, bit 1 = 0): the pin is pulled low exactly while the alarm flag is set.
- R10: Calibration mode (control bit 1 = 1, whatever bit 0 holds): the pin carries a continuous 512 Hz square wave, which is 128 strobes per period.
- R11: Square-wave mode (control bits 1:0 = 00): control bits 3:2 choose the rate. 0 gives 1 Hz, 1 gives 512 Hz, 2 gives 4096 Hz and 3 gives 32768 Hz, which is 2^PRESC_W, 128, 16 and 2 strobes per period.
- R12: `mp_level` reads low exactly when the pin is pulled down and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_edge | input | 1 | One-cycle strobe per half period of the 32.768 kHz timebase |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| rd_strobe | input | 1 | Capture the time fields for reading |
| reg_rdata | output | 8 | Register read data (captured time or live configuration) |
| mp_oe | output | 1 | Multipurpose pin pull-down enable |
| mp_level | output | 1 | Level seen on the multipurpose pin |

## Verification
Several rules are checked by assertions on every cycle:
- the prescaler clears when a time field is written and wraps to zero on each second tick;
- the time holds still between ticks;
- the 59-to-00 seconds carry and the leap-year 28th-to-29th February step behave as required;
- the read capture stays frozen between strobes;
- the alarm flag only rises right after an update and stays set until it is cleared;
- alarm mode pulls the pin low, and the fastest square wave toggles on every strobe.

Other behaviour only the bench scenarios can show. These are the full cascade from 31 December 1999-style values into a new century, the month-length table, and the exact delay after a write. They also cover the multi-field alarm mask and the measured periods of the calibration tone and each square-wave rate.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Packed so that address n selects bits [8n+7:8n]; seconds sit lowest.
  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] dow;
    logic [7:0] hrs;
    logic [7:0] mins;
    logic [7:0] secs;
  } rtc_time_t;

  // Fields the alarm compares; field n matches mask bit n.
  typedef struct packed {
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] hrs;
    logic [7:0] mins;
    logic [7:0] secs;
  } alm_view_t;

  localparam int unsigned ALM_FIELDS = 5;
  localparam logic [3:0]  ADDR_MASK  = 4'd13;
  localparam logic [3:0]  ADDR_CTRL  = 4'd14;

  localparam rtc_time_t RESET_TIME = '{cent: 8'h20, yr: 8'h00, mon: 8'h01,
                                       mday: 8'h01, dow: 8'h01, hrs: 8'h00,
                                       mins: 8'h00, secs: 8'h00};

  typedef enum logic [1:0] {SQW_1HZ = 2'd0, SQW_512 = 2'd1,
                            SQW_4K  = 2'd2, SQW_32K = 2'd3} sqw_sel_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Value mod 4 of (10*tens + ones) equals (2*tens + ones) mod 4.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [5:0] s;
    s = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t advance(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.secs != 8'h59) n.secs = bcd_inc(t.secs);
    else begin
      n.secs = 8'h00;
      if (t.mins != 8'h59) n.mins = bcd_inc(t.mins);
      else begin
        n.mins = 8'h00;
        if (t.hrs != 8'h23) n.hrs = bcd_inc(t.hrs);
        else begin
          n.hrs = 8'h00;
          n.dow = (t.dow == 8'h07) ? 8'h01 : bcd_inc(t.dow);
          if (t.mday != month_last_day(t.mon, t.yr)) n.mday = bcd_inc(t.mday);
          else begin
            n.mday = 8'h01;
            if (t.mon != 8'h12) n.mon = bcd_inc(t.mon);
            else begin
              n.mon = 8'h01;
              if (t.yr != 8'h99) n.yr = bcd_inc(t.yr);
              else begin
                n.yr   = 8'h00;
                n.cent = (t.cent == 8'h99) ? 8'h00 : bcd_inc(t.cent);
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESC_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_edge,
  input  logic       clr,
  output logic       sec_tick,
  output logic [3:0] taps      // {1 Hz, 512 Hz, 4096 Hz, 32768 Hz}
);
  localparam int unsigned TOP    = PRESC_W - 1;
  localparam int unsigned T_512  = (TOP < 6) ? TOP : 6;
  localparam int unsigned T_4K   = (TOP < 3) ? TOP : 3;

  logic [PRESC_W-1:0] cnt;

  assign sec_tick = osc_edge && !clr && (cnt == {PRESC_W{1'b1}});
  assign taps     = {cnt[TOP], cnt[T_512], cnt[T_4K], cnt[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (osc_edge) cnt <= cnt + 1'b1;
  end

  // R6
  presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R2
  presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (cnt == '0));

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic       rd_strobe,
  output rtc_time_t  snap,
  output alm_view_t  alm_now
);
  rtc_time_t cur, nxt;

  always_comb begin
    nxt = cur;
    if (wr_en)         nxt[{wr_idx, 3'b000} +: 8] = wr_data;
    else if (sec_tick) nxt = advance(cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= RESET_TIME;
      snap <= RESET_TIME;
    end else begin
      cur <= nxt;
      if (rd_strobe) snap <= cur;
    end
  end

  assign alm_now = '{mon: cur.mon, mday: cur.mday, hrs: cur.hrs,
                     mins: cur.mins, secs: cur.secs};

  // R2
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_en) |=> $stable(cur));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en && cur.secs == 8'h59) |=> (cur.secs == 8'h00));

  // R5
  leap_day_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en && cur.mon == 8'h02 && cur.mday == 8'h28 &&
     cur.hrs == 8'h23 && cur.mins == 8'h59 && cur.secs == 8'h59 &&
     is_leap(cur.yr)) |=> (cur.mday == 8'h29));

  // R7
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(snap));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sec_tick,
  input  alm_view_t             now,
  input  alm_view_t             target,
  input  logic [ALM_FIELDS-1:0] mask,
  input  logic                  flag_clr,
  output logic                  flag
);
  logic [ALM_FIELDS-1:0] hit;
  logic                  match;
  logic                  tick_q;   // time registers hold the new second now

  for (genvar gi = 0; gi < ALM_FIELDS; gi++) begin : g_field
    assign hit[gi] = !mask[gi] || (now[gi*8 +: 8] == target[gi*8 +: 8]);
  end

  assign match = (|mask) && (&hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      tick_q <= sec_tick;
      if (tick_q && match) flag <= 1'b1;
      else if (flag_clr)   flag <= 1'b0;
    end
  end

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  // R8
  flag_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick_q));

endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux
  import rtc_pkg::*;
(
  input  logic       alarm_mode,
  input  logic       cal_mode,
  input  sqw_sel_e   sel,
  input  logic [3:0] taps,
  input  logic       alarm_flag,
  output logic       pull_low
);
  always_comb begin
    if (cal_mode)        pull_low = taps[2];
    else if (alarm_mode) pull_low = alarm_flag;
    else begin
      case (sel)
        SQW_1HZ: pull_low = taps[3];
        SQW_512: pull_low = taps[2];
        SQW_4K:  pull_low = taps[1];
        default: pull_low = taps[0];
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRESC_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_edge,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       rd_strobe,
  output logic [7:0] reg_rdata,
  output logic       mp_oe,
  output logic       mp_level
);
  logic       time_wr, flag_clr, sec_tick, alarm_flag;
  logic       alarm_mode, cal_mode;
  sqw_sel_e   sqw_sel;
  logic [3:0] taps;
  logic [ALM_FIELDS-1:0] alm_mask;
  logic [7:0] alm_cfg [ALM_FIELDS];
  rtc_time_t  snap;
  alm_view_t  alm_now, alm_target;

  assign time_wr  = reg_wr && !reg_addr[3];
  assign flag_clr = reg_wr && (reg_addr == ADDR_CTRL) && !reg_wdata[7];

  for (genvar gi = 0; gi < ALM_FIELDS; gi++) begin : g_alm_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_cfg[gi] <= 8'h00;
      else if (reg_wr && reg_addr == 4'(8 + gi)) alm_cfg[gi] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_mask   <= '0;
      alarm_mode <= 1'b0;
      cal_mode   <= 1'b0;
      sqw_sel    <= SQW_1HZ;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_MASK) alm_mask <= reg_wdata[ALM_FIELDS-1:0];
      if (reg_addr == ADDR_CTRL) begin
        alarm_mode <= reg_wdata[0];
        cal_mode   <= reg_wdata[1];
        sqw_sel    <= sqw_sel_e'(reg_wdata[3:2]);
      end
    end
  end

  assign alm_target = '{mon: alm_cfg[4], mday: alm_cfg[3], hrs: alm_cfg[2],
                        mins: alm_cfg[1], secs: alm_cfg[0]};

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .osc_edge(osc_edge), .clr(time_wr),
    .sec_tick(sec_tick), .taps(taps));

  rtc_timekeeper u_time (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(time_wr),
    .wr_idx(reg_addr[2:0]), .wr_data(reg_wdata), .rd_strobe(rd_strobe),
    .snap(snap), .alm_now(alm_now));

  rtc_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now(alm_now),
    .target(alm_target), .mask(alm_mask), .flag_clr(flag_clr),
    .flag(alarm_flag));

  rtc_pin_mux u_pin (
    .alarm_mode(alarm_mode), .cal_mode(cal_mode), .sel(sqw_sel),
    .taps(taps), .alarm_flag(alarm_flag), .pull_low(mp_oe));

  assign mp_level = !mp_oe;

  always_comb begin
    case (reg_addr)
      4'd8, 4'd9, 4'd10, 4'd11, 4'd12:
                 reg_rdata = alm_cfg[reg_addr - 4'd8];
      ADDR_MASK: reg_rdata = {{(8-ALM_FIELDS){1'b0}}, alm_mask};
      ADDR_CTRL: reg_rdata = {alarm_flag, 3'b000, sqw_sel, cal_mode, alarm_mode};
      4'd15:     reg_rdata = 8'h00;
      default:   reg_rdata = snap[{reg_addr[2:0], 3'b000} +: 8];
    endcase
  end

  // R9
  alarm_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_mode && !cal_mode && alarm_flag) |-> !mp_level);

  // R11
  fast_sqw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_mode && !cal_mode && sqw_sel == SQW_32K && osc_edge && !reg_wr)
      |=> (mp_oe != $past(mp_oe)));

endmodule

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
  localparam int unsigned PW = 8;   // 256 strobes per second

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_edge = 1'b1;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       rd_strobe = 1'b0;
  logic [7:0] reg_rdata;
  logic       mp_oe, mp_level;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar_core #(.PRESC_W(PW)) u_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .osc_edge(osc_edge), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rd_strobe(rd_strobe),
    .reg_rdata(reg_rdata), .mp_oe(mp_oe), .mp_level(mp_level));

  typedef struct {
    string      tag;
    logic [3:0] a;
    logic [7:0] v;
  } exp_t;

  exp_t sb_q[$];
  event mon_ev;

  // Monitor: pops the expected item and compares with the read port.
  always @(mon_ev) begin
    exp_t it;
    it = sb_q.pop_front();
    nchk++;
    if (reg_rdata !== it.v) begin
      nbad++;
      $display("FAIL %s addr %0d: actual %h expected %h", it.tag, it.a, reg_rdata, it.v);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic snap();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  // Driver: queues the expected item, presents the address, fires the monitor.
  task automatic rd_exp(input logic [3:0] a, input logic [7:0] v, input string tag);
    exp_t it;
    it.tag = tag; it.a = a; it.v = v;
    sb_q.push_back(it);
    reg_addr = a;
    @(negedge clk);
    -> mon_ev;
    #1;
  endtask

  task automatic set_eod(input logic [7:0] yr, input logic [7:0] mon, input logic [7:0] md);
    wr(4'd6, yr); wr(4'd5, mon); wr(4'd4, md);
    wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
  endtask

  task automatic count_toggles(output int n);
    logic prev;
    prev = mp_oe;
    n = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (mp_oe !== prev) n++;
      prev = mp_oe;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    snap();
    rd_exp(0, 8'h00, "R1"); rd_exp(1, 8'h00, "R1"); rd_exp(2, 8'h00, "R1");
    rd_exp(3, 8'h01, "R1"); rd_exp(4, 8'h01, "R1"); rd_exp(5, 8'h01, "R1");
    rd_exp(6, 8'h00, "R1"); rd_exp(7, 8'h20, "R1"); rd_exp(14, 8'h00, "R1");
    chk("R1 pin released", {31'b0, mp_oe}, 0);
    chk("R12 released level", {31'b0, mp_level}, 1);

    // R6 / R2: exact advance point after a write, then full cascade
    wr(7, 8'h20); wr(6, 8'h99); wr(5, 8'h12); wr(4, 8'h31);
    wr(3, 8'h07); wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h58);
    repeat (254) @(negedge clk);
    snap();                         // capture before the advance
    rd_exp(0, 8'h58, "R6 before");
    snap();                         // capture after the advance
    rd_exp(0, 8'h59, "R6 after");
    repeat (300) @(negedge clk);
    snap();
    rd_exp(0, 8'h00, "R3"); rd_exp(1, 8'h00, "R3"); rd_exp(2, 8'h00, "R3");
    rd_exp(3, 8'h01, "R4"); rd_exp(4, 8'h01, "R5"); rd_exp(5, 8'h01, "R5");
    rd_exp(6, 8'h00, "R5"); rd_exp(7, 8'h21, "R5");

    // R7 capture stays frozen while time runs
    snap();
    repeat (600) @(negedge clk);
    rd_exp(0, 8'h00, "R7 frozen");
    snap();
    rd_exp(0, 8'h02, "R7 refreshed");

    // R2 no strobes, no advance
    osc_edge = 1'b0;
    wr(0, 8'h10);
    repeat (600) @(negedge clk);
    snap();
    rd_exp(0, 8'h10, "R2 idle");
    osc_edge = 1'b1;

    // R5 month lengths
    set_eod(8'h24, 8'h02, 8'h28); repeat (300) @(negedge clk); snap();
    rd_exp(4, 8'h29, "R5 leap"); rd_exp(5, 8'h02, "R5 leap");
    set_eod(8'h24, 8'h02, 8'h29); repeat (300) @(negedge clk); snap();
    rd_exp(4, 8'h01, "R5 leap end"); rd_exp(5, 8'h03, "R5 leap end");
    set_eod(8'h23, 8'h02, 8'h28); repeat (300) @(negedge clk); snap();
    rd_exp(4, 8'h01, "R5 common"); rd_exp(5, 8'h03, "R5 common");
    set_eod(8'h23, 8'h04, 8'h30); repeat (300) @(negedge clk); snap();
    rd_exp(4, 8'h01, "R5 30day"); rd_exp(5, 8'h05, "R5 30day");
    set_eod(8'h23, 8'h01, 8'h30); repeat (300) @(negedge clk); snap();
    rd_exp(4, 8'h31, "R5 31day"); rd_exp(5, 8'h01, "R5 31day");

    // R8 / R9 alarm on seconds only
    wr(14, 8'h01); wr(13, 8'h01); wr(8, 8'h05); wr(0, 8'h03);
    repeat (300) @(negedge clk);
    chk("R9 before match", {31'b0, mp_oe}, 0);
    repeat (250) @(negedge clk);
    chk("R9 on match", {31'b0, mp_oe}, 1);
    chk("R12 pulled level", {31'b0, mp_level}, 0);
    rd_exp(14, 8'h81, "R8 flag");
    repeat (300) @(negedge clk);
    chk("R8 sticky", {31'b0, mp_oe}, 1);
    wr(14, 8'h01);
    chk("R8 cleared", {31'b0, mp_oe}, 0);

    // R8 empty mask never matches
    wr(13, 8'h00); wr(0, 8'h04);
    repeat (300) @(negedge clk);
    chk("R8 empty mask", {31'b0, mp_oe}, 0);
    rd_exp(14, 8'h01, "R8 empty mask");

    // R8 two fields: minutes differ, then agree
    wr(13, 8'h03); wr(9, 8'h11); wr(1, 8'h10); wr(0, 8'h04);
    repeat (300) @(negedge clk);
    chk("R8 partial match", {31'b0, mp_oe}, 0);
    wr(1, 8'h11); wr(0, 8'h04);
    repeat (300) @(negedge clk);
    chk("R8 full match", {31'b0, mp_oe}, 1);
    wr(14, 8'h01);

    // R10 calibration wins over alarm mode
    wr(14, 8'h03);
    count_toggles(n);
    chk("R10 cal toggles", n, 4);
    chk("R12 level tracks", {31'b0, mp_level}, {31'b0, ~mp_oe});

    // R11 square-wave rates
    wr(14, 8'h00); count_toggles(n); chk("R11 1Hz", n, 2);
    wr(14, 8'h04); count_toggles(n); chk("R11 512Hz", n, 4);
    wr(14, 8'h08); count_toggles(n); chk("R11 4096Hz", n, 32);
    wr(14, 8'h0C); count_toggles(n); chk("R11 32768Hz", n, 256);
    rd_exp(14, 8'h0C, "R11 ctrl");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule